// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine that has no broadcast medium. For every memory block the home node owns, it keeps a directory entry and the block's data. A directory entry holds one of three states, plus a per-processor presence vector. Local nodes send read-miss, write-miss and write-back messages over a single in-order request port. The controller answers every request with an explicit message on a single outgoing port. When coherence requires it, it sends point-to-point invalidate or fetch messages to the nodes that hold copies.

The directory states are as follows. Uncached means no node holds the block. Shared means one or more nodes hold clean copies and memory is current. Exclusive means exactly one node owns the block and memory may be stale. When a request finds the block owned by another node, the controller issues a fetch (or a fetch-and-invalidate) to the owner and parks in a waiting state. It then forwards the owner's returned data to the requester and writes that data back into memory. Directory and data arrays have one synchronous read port and one write port each, so they map onto block RAM. After reset they are cleared by a sweep, one entry per cycle.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for BLOCKS-1 sampled cycles while the arrays are cleared, and `out_valid` stays low. Afterwards every block is Uncached and holds data 0.
- R2: A read miss (type 0) to an Uncached or Shared block returns a data reply (out type 4) with the memory value to the requester. The reply appears on the second clock edge after acceptance. The requester is added to the sharer set.
- R3: A write miss (type 1) to an Uncached block returns a data reply on the second edge after acceptance. The requester becomes the sole Exclusive owner.
- R4: A write miss to a Shared block sends one invalidate (out type 1) per cycle to each sharer other than the requester, in ascending node order, starting on the third edge after acceptance. The data reply follows on the next edge, and the requester becomes the sole Exclusive owner.
- R5: A read miss to an Exclusive block sends a fetch (out type 2) to the owner on the second edge. The owner then answers with a fetch-data message (type 3). That data is written to memory and sent to the requester as a data reply on the edge that accepts it. Owner and requester both end up as sharers in Shared.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate (out type 3) to the owner. The returned data is forwarded to the requester as a data reply, and the requester becomes the sole Exclusive owner.
- R7: A write-back (type 2) from the Exclusive owner writes its data into memory, sets the entry to Uncached with an empty vector, and returns an acknowledge (out type 5) on the second edge.
- R8: A write-back from a node that is not the Exclusive owner is acknowledged but changes neither memory nor the directory.
- R9: While a fetch is outstanding, only a fetch-data message is accepted. Any other request is held with `req_ready` low, and no output is produced.
- R10: A fetch-data message that arrives when no fetch is outstanding is accepted and dropped with no output.
- R11: Every outgoing message carries the block number of the transaction in `out_blk`. Invalidate, fetch and acknowledge messages carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted on this edge when high with `req_valid` |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 fetch data |
| req_src | input | $clog2(NODES) | Sending node |
| req_blk | input | $clog2(BLOCKS) | Block number |
| req_data | input | DATA_W | Data of a write-back or fetch-data message |
| out_valid | output | 1 | Outgoing message valid for one cycle |
| out_type | output | 3 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 data reply, 5 acknowledge |
| out_dst | output | $clog2(NODES) | Destination node |
| out_blk | output | $clog2(BLOCKS) | Block number |
| out_data | output | DATA_W | Block data for replies, zero otherwise |

## Verification
Write misses are tried against every one of the sixteen sharer sets of a four-node setup, and from every requester. This separates a correct invalidate list (requester excluded, ascending order, one per cycle) from an off-by-one scan or a missing exclusion. Read and write misses are then issued to blocks owned by each node, from each node. These cases check that the fetch goes to the right owner, that the forwarded data is what the owner returned, and that the final sharer set is correct. A request is also held against the port during each outstanding fetch. Write-backs from owners and non-owners, stray fetch data, and a long pseudo-random mix of all message types complete the stimulus. A reference model in the bench predicts every message, its cycle and its payload.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [1:0] {
    REQ_RD = 2'd0,
    REQ_WR = 2'd1,
    REQ_WB = 2'd2,
    REQ_FD = 2'd3
  } req_e;

  typedef enum logic [2:0] {
    MSG_NONE      = 3'd0,
    MSG_INV       = 3'd1,
    MSG_FETCH     = 3'd2,
    MSG_FETCH_INV = 3'd3,
    MSG_DATA      = 3'd4,
    MSG_ACK       = 3'd5
  } msg_e;

  typedef enum logic [1:0] {
    DS_U = 2'd0,
    DS_S = 2'd1,
    DS_E = 2'd2
  } dstate_e;
endpackage

// File: rtl/hd_store.sv
module hd_store #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int DIR_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DIR_W-1:0]  dir_q,
  output logic [DATA_W-1:0] mem_q,
  input  logic              dir_we,
  input  logic [AW-1:0]     dir_wa,
  input  logic [DIR_W-1:0]  dir_wd,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_wa,
  input  logic [DATA_W-1:0] mem_wd
);
  logic [DIR_W-1:0]  dir_ram [DEPTH];
  logic [DATA_W-1:0] dat_ram [DEPTH];

  // directory array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (dir_we) dir_ram[dir_wa] <= dir_wd;
    if (rd_en)  dir_q <= dir_ram[rd_addr];
  end

  // block data array, same organisation
  always_ff @(posedge clk) begin
    if (mem_we) dat_ram[mem_wa] <= mem_wd;
    if (rd_en)  mem_q <= dat_ram[rd_addr];
  end
endmodule

// File: rtl/hd_lowbit.sv
module hd_lowbit #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_pick
      assign oh[g]     = vec[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec[g];
    end
  endgenerate

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hd_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_type,
  input  logic [$clog2(NODES)-1:0]  req_src,
  input  logic [$clog2(BLOCKS)-1:0] req_blk,
  input  logic [DATA_W-1:0]         req_data,
  output logic                      out_valid,
  output logic [2:0]                out_type,
  output logic [$clog2(NODES)-1:0]  out_dst,
  output logic [$clog2(BLOCKS)-1:0] out_blk,
  output logic [DATA_W-1:0]         out_data
);
  localparam int NW    = $clog2(NODES);
  localparam int AW    = $clog2(BLOCKS);
  localparam int DIR_W = 2 + NODES;

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_LOOK, S_INVAL, S_WAIT
  } fsm_e;

  fsm_e               fsm;
  logic [AW-1:0]      init_cnt;
  req_e               cur_type;
  logic [NW-1:0]      cur_src;
  logic [AW-1:0]      cur_blk;
  logic [DATA_W-1:0]  cur_data;
  logic [NODES-1:0]   inv_mask;
  logic               pend_wr;
  logic [NODES-1:0]   pend_own;

  logic               accept;
  logic               rd_en;
  logic [DIR_W-1:0]   dir_q;
  logic [DATA_W-1:0]  mem_q;
  dstate_e            rd_st;
  logic [NODES-1:0]   rd_vec;
  logic [NODES-1:0]   src_oh;

  logic               dir_we, mem_we;
  logic [AW-1:0]      dir_wa;
  logic [DIR_W-1:0]   dir_wd;
  logic [DATA_W-1:0]  mem_wd;

  logic [NODES-1:0]   pick_in, pick_oh;
  logic [NW-1:0]      pick_idx;
  logic               pick_any;

  assign req_ready = (fsm == S_IDLE) ||
                     ((fsm == S_WAIT) && (req_type == REQ_FD));
  assign accept    = req_valid && req_ready;
  assign rd_en     = accept && (fsm == S_IDLE);

  assign rd_st  = dstate_e'(dir_q[DIR_W-1 -: 2]);
  assign rd_vec = dir_q[NODES-1:0];
  assign src_oh = {{(NODES-1){1'b0}}, 1'b1} << cur_src;

  assign pick_in = (fsm == S_INVAL) ? inv_mask : rd_vec;

  hd_store #(
    .DEPTH (BLOCKS),
    .AW    (AW),
    .DIR_W (DIR_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk    (clk),
    .rd_en  (rd_en),
    .rd_addr(req_blk),
    .dir_q  (dir_q),
    .mem_q  (mem_q),
    .dir_we (dir_we),
    .dir_wa (dir_wa),
    .dir_wd (dir_wd),
    .mem_we (mem_we),
    .mem_wa (dir_wa),
    .mem_wd (mem_wd)
  );

  hd_lowbit #(
    .N (NODES),
    .IW(NW)
  ) u_pick (
    .vec(pick_in),
    .oh (pick_oh),
    .idx(pick_idx),
    .any(pick_any)
  );

  // array write controls
  always_comb begin
    dir_we = 1'b0;
    mem_we = 1'b0;
    dir_wa = (fsm == S_INIT) ? init_cnt : cur_blk;
    dir_wd = '0;
    mem_wd = '0;
    unique case (fsm)
      S_INIT: begin
        dir_we = 1'b1;
        mem_we = 1'b1;
      end
      S_LOOK: begin
        unique case (cur_type)
          REQ_RD: if (rd_st != DS_E) begin
            dir_we = 1'b1;
            dir_wd = {DS_S, rd_vec | src_oh};
          end
          REQ_WR: if ((rd_st != DS_E) && (rd_st != DS_S)) begin
            dir_we = 1'b1;
            dir_wd = {DS_E, src_oh};
          end
          REQ_WB: if ((rd_st == DS_E) && (rd_vec == src_oh)) begin
            dir_we = 1'b1;
            dir_wd = {DS_U, {NODES{1'b0}}};
            mem_we = 1'b1;
            mem_wd = cur_data;
          end
          default: ;
        endcase
      end
      S_INVAL: if (!pick_any) begin
        dir_we = 1'b1;
        dir_wd = {DS_E, src_oh};
      end
      S_WAIT: if (accept) begin
        mem_we = 1'b1;
        mem_wd = req_data;
        dir_we = 1'b1;
        dir_wd = pend_wr ? {DS_E, src_oh} : {DS_S, src_oh | pend_own};
      end
      default: ;
    endcase
  end

  // sequencing and registered outgoing message
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm       <= S_INIT;
      init_cnt  <= '0;
      cur_type  <= REQ_RD;
      cur_src   <= '0;
      cur_blk   <= '0;
      cur_data  <= '0;
      inv_mask  <= '0;
      pend_wr   <= 1'b0;
      pend_own  <= '0;
      out_valid <= 1'b0;
      out_type  <= MSG_NONE;
      out_dst   <= '0;
      out_blk   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_type  <= MSG_NONE;
      out_data  <= '0;
      unique case (fsm)
        S_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == AW'(BLOCKS - 1)) fsm <= S_IDLE;
        end
        S_IDLE: if (accept) begin
          cur_type <= req_e'(req_type);
          cur_src  <= req_src;
          cur_blk  <= req_blk;
          cur_data <= req_data;
          fsm      <= (req_type == REQ_FD) ? S_IDLE : S_LOOK;
        end
        S_LOOK: begin
          out_blk <= cur_blk;
          fsm     <= S_IDLE;
          unique case (cur_type)
            REQ_RD: begin
              out_valid <= 1'b1;
              if (rd_st == DS_E) begin
                out_type <= MSG_FETCH;
                out_dst  <= pick_idx;
                pend_wr  <= 1'b0;
                pend_own <= rd_vec;
                fsm      <= S_WAIT;
              end else begin
                out_type <= MSG_DATA;
                out_dst  <= cur_src;
                out_data <= mem_q;
              end
            end
            REQ_WR: begin
              if (rd_st == DS_S) begin
                inv_mask <= rd_vec & ~src_oh;
                fsm      <= S_INVAL;
              end else if (rd_st == DS_E) begin
                out_valid <= 1'b1;
                out_type  <= MSG_FETCH_INV;
                out_dst   <= pick_idx;
                pend_wr   <= 1'b1;
                pend_own  <= rd_vec;
                fsm       <= S_WAIT;
              end else begin
                out_valid <= 1'b1;
                out_type  <= MSG_DATA;
                out_dst   <= cur_src;
                out_data  <= mem_q;
              end
            end
            REQ_WB: begin
              out_valid <= 1'b1;
              out_type  <= MSG_ACK;
              out_dst   <= cur_src;
            end
            default: ;
          endcase
        end
        S_INVAL: begin
          out_valid <= 1'b1;
          out_blk   <= cur_blk;
          if (pick_any) begin
            out_type <= MSG_INV;
            out_dst  <= pick_idx;
            inv_mask <= inv_mask & ~pick_oh;
          end else begin
            out_type <= MSG_DATA;
            out_dst  <= cur_src;
            out_data <= mem_q;
            fsm      <= S_IDLE;
          end
        end
        S_WAIT: if (accept) begin
          out_valid <= 1'b1;
          out_type  <= MSG_DATA;
          out_dst   <= cur_src;
          out_blk   <= cur_blk;
          out_data  <= req_data;
          fsm       <= S_IDLE;
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end

  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm == S_INIT) |=> !out_valid);

  // R2
  lookup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm == S_IDLE && accept) |=> !out_valid);

  // R4
  inv_not_req_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_type == MSG_INV) |-> (out_dst != cur_src));

  // R6
  excl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_we && dir_wd[DIR_W-1 -: 2] == DS_E) |-> ($countones(dir_wd[NODES-1:0]) == 1));

  // R7
  unc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_we && dir_wd[DIR_W-1 -: 2] == DS_U) |-> (dir_wd[NODES-1:0] == '0));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm == S_WAIT && !accept) |=> (fsm == S_WAIT && !out_valid));
endmodule

// File: tb/home_dir_ctrl_tb.sv
`timescale 1ns/1ps
module home_dir_ctrl_tb;
  localparam int N  = 4;
  localparam int B  = 4;
  localparam int DW = 16;
  localparam int NW = $clog2(N);
  localparam int AW = $clog2(B);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_type = 2'd0;
  logic [NW-1:0] req_src = '0;
  logic [AW-1:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic          out_valid;
  logic [2:0]    out_type;
  logic [NW-1:0] out_dst;
  logic [AW-1:0] out_blk;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  home_dir_ctrl #(.NODES(N), .BLOCKS(B), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .out_valid(out_valid), .out_type(out_type), .out_dst(out_dst),
    .out_blk(out_blk), .out_data(out_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference directory: 0 Uncached, 1 Shared, 2 Exclusive
  int            m_st  [B];
  logic [N-1:0]  m_vec [B];
  logic [DW-1:0] m_mem [B];
  logic [DW-1:0] dseed = 16'h0101;
  int unsigned   lcg = 32'h1234_5678;

  int ex_t[12], ex_d[12], ex_c[12]; logic [DW-1:0] ex_v[12]; int ne;
  int go_t[12], go_d[12], go_c[12]; logic [DW-1:0] go_v[12]; int ng;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int t, int d, int c, logic [DW-1:0] v);
    ex_t[ne] = t; ex_d[ne] = d; ex_c[ne] = c; ex_v[ne] = v; ne++;
  endtask

  task automatic send(int t, int src, int blk, logic [DW-1:0] d);
    req_valid = 1'b1; req_type = 2'(t); req_src = NW'(src);
    req_blk = AW'(blk); req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic collect(int win, int blk);
    ng = 0;
    for (int c = 1; c <= win; c++) begin
      @(negedge clk);
      if (out_valid) begin
        chk(int'(out_blk) == blk, "R11", "out_blk", int'(out_blk), blk);
        if (ng < 12) begin
          go_t[ng] = int'(out_type); go_d[ng] = int'(out_dst);
          go_c[ng] = c; go_v[ng] = out_data; ng++;
        end
      end
    end
  endtask

  task automatic compare(string req);
    chk(ng == ne, req, "message count", ng, ne);
    for (int i = 0; i < ne && i < ng; i++) begin
      chk(go_t[i] == ex_t[i], req, "type", go_t[i], ex_t[i]);
      chk(go_d[i] == ex_d[i], req, "dst", go_d[i], ex_d[i]);
      chk(go_c[i] == ex_c[i], req, "cycle", go_c[i], ex_c[i]);
      chk(go_v[i] == ex_v[i], req, "data", int'(go_v[i]), int'(ex_v[i]));
    end
  endtask

  function automatic int low_idx(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  // fetch path: R9 hold check, then owner answers with fresh data
  task automatic fetch_path(int src, int blk, bit wr, string tag);
    int own = low_idx(m_vec[blk]);
    logic [DW-1:0] nd;
    ne = 0;
    push(wr ? 3 : 2, own, 2, '0);
    send(wr ? 1 : 0, src, blk, '0);
    collect(6, blk);
    compare(tag);
    req_valid = 1'b1; req_type = 2'd0; req_src = NW'((src + 1) % N); req_blk = AW'(blk);
    #1;
    chk(req_ready == 1'b0, "R9", "ready while fetch pending", int'(req_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!out_valid && !req_ready, "R9", "held request quiet", int'(out_valid), 0);
    end
    dseed = dseed + 16'h1357;
    nd = dseed;
    ne = 0;
    push(4, src, 1, nd);
    send(3, own, blk, nd);
    collect(4, blk);
    compare(tag);
    m_mem[blk] = nd;
    if (wr) begin m_st[blk] = 2; m_vec[blk] = N'(1) << src; end
    else begin m_st[blk] = 1; m_vec[blk] = m_vec[blk] | (N'(1) << src); end
  endtask

  task automatic op(int t, int src, int blk, string tag_in);
    string tag;
    logic [DW-1:0] nd;
    int k;
    ne = 0;
    case (t)
      0: begin
        tag = (tag_in != "") ? tag_in : "R2";
        if (m_st[blk] == 2) begin
          fetch_path(src, blk, 1'b0, (tag_in != "") ? tag_in : "R5");
          return;
        end
        push(4, src, 2, m_mem[blk]);
        send(0, src, blk, '0);
        collect(N + 6, blk);
        compare(tag);
        m_st[blk] = 1; m_vec[blk] = m_vec[blk] | (N'(1) << src);
      end
      1: begin
        if (m_st[blk] == 2) begin
          fetch_path(src, blk, 1'b1, (tag_in != "") ? tag_in : "R6");
          return;
        end
        if (m_st[blk] == 1) begin
          tag = (tag_in != "") ? tag_in : "R4";
          k = 0;
          for (int n = 0; n < N; n++)
            if (m_vec[blk][n] && n != src) begin push(1, n, 3 + k, '0); k++; end
          push(4, src, 3 + k, m_mem[blk]);
        end else begin
          tag = (tag_in != "") ? tag_in : "R3";
          push(4, src, 2, m_mem[blk]);
        end
        send(1, src, blk, '0);
        collect(N + 6, blk);
        compare(tag);
        m_st[blk] = 2; m_vec[blk] = N'(1) << src;
      end
      2: begin
        dseed = dseed + 16'h0b1d;
        nd = dseed;
        push(5, src, 2, '0);
        if (m_st[blk] == 2 && m_vec[blk] == (N'(1) << src)) begin
          tag = (tag_in != "") ? tag_in : "R7";
          m_mem[blk] = nd; m_st[blk] = 0; m_vec[blk] = '0;
        end else tag = (tag_in != "") ? tag_in : "R8";
        send(2, src, blk, nd);
        collect(N + 6, blk);
        compare(tag);
      end
      default: begin
        tag = (tag_in != "") ? tag_in : "R10";
        send(3, src, blk, 16'hdead);
        collect(N + 6, blk);
        compare(tag);
      end
    endcase
  endtask

  task automatic make_unc(int blk);
    if (m_st[blk] == 1) op(1, 0, blk, "");
    if (m_st[blk] == 2) op(2, low_idx(m_vec[blk]), blk, "R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int b = 0; b < B; b++) begin m_st[b] = 0; m_vec[b] = '0; m_mem[b] = '0; end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      chk(!out_valid, "R1", "out_valid during clear", int'(out_valid), 0);
      if (req_ready) break;
      cnt++;
    end
    chk(cnt == B - 1, "R1", "clear sweep length", cnt, B - 1);
    // every block reads back zero after the sweep
    for (int b = 0; b < B; b++) op(0, b % N, b, "R1");
    for (int b = 0; b < B; b++) make_unc(b);

    // stray fetch data and non-owner write-back
    op(3, 1, 0, "R10");
    op(1, 2, 1, "");
    op(2, 3, 1, "R8");
    op(0, 0, 1, "R8");
    make_unc(1);

    // every sharer set against every requester
    for (int b = 0; b < B; b++)
      for (int m = 0; m < (1 << N); m++)
        for (int r = 0; r < N; r++) begin
          make_unc(b);
          for (int n = 0; n < N; n++) if (m[n]) op(0, n, b, "");
          op(1, r, b, "");
          op(2, r, b, "R7");
        end

    // owner / requester / kind sweep over exclusive blocks
    for (int o = 0; o < N; o++)
      for (int r = 0; r < N; r++)
        for (int w = 0; w < 2; w++) begin
          make_unc(2);
          op(1, o, 2, "");
          op(w, r, 2, "");
        end

    // pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      int t, s, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      t = int'((lcg >> 24) % 8);
      s = int'((lcg >> 8) % N);
      b = int'((lcg >> 16) % B);
      if (t >= 4) t = (t == 7) ? 3 : (t - 4);
      if (t == 2 && m_st[b] == 2 && ((lcg >> 4) & 1) == 1) s = low_idx(m_vec[b]);
      op(t, s, b, "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule